// File: doc/BRIEF.md
# Sequential Block Stream Buffer

This block sits next to a cache and holds a short run of blocks fetched ahead of demand, at consecutive block addresses. The blocks stay in the buffer, not in the cache, until the cache asks for them. On every cache miss the cache first presents the missing block address to the buffer. Only the oldest entry is compared with that address.

If the oldest entry matches and its data has arrived, the block is handed back in the same cycle. Its slot is then reused for the block one past the newest address already requested. If the oldest entry does not match, every entry is dropped and the lookup is answered as a miss, which the cache then serves from the next level itself. The buffer restarts by requesting the DEPTH blocks that follow the missed address.

Requests to the next level carry a generation tag, and responses echo it. Responses come back in request order. A response whose tag is not the current generation belongs to a stream that was abandoned, and it is dropped.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset the buffer is empty: `miss_ready` is 1, `lkp_hit` is 0 and `mem_req_valid` stays 0 until the first lookup is accepted.
- R2: A lookup that is accepted with `lkp_hit`=0 flushes the buffer and increments the generation. The buffer then requests block addresses miss+1, miss+2, …, miss+DEPTH in that order, each tagged with the new generation on `mem_req_gen`.
- R3: A lookup whose address equals the oldest entry's tag, when that entry's data has arrived, is accepted in the same cycle with `lkp_hit`=1 and `lkp_data` equal to that block's data.
- R4: Each accepted hit frees one slot. The next request issued for it has the address of the newest block requested so far plus one.
- R5: A lookup that matches the oldest entry before its data has arrived is held with `miss_ready`=0 until the data is filled. It then completes as a hit, and no second request is issued for that block.
- R6: Only the oldest entry is compared. A lookup for an address held in any other entry is a miss and flushes the buffer.
- R7: A response whose `mem_rsp_gen` differs from the current generation, or one that arrives in a flush cycle, is discarded and fills no entry.
- R8: At most DEPTH requests are outstanding or held at a time. With no responses and no hits, exactly DEPTH requests follow a flush.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request address and generation stay unchanged, unless a flush occurs.
- R10: Responses with the current generation fill the pending entries in the order their requests were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a missing block address |
| miss_addr | input | ADDR_W | Missing block address (block units) |
| miss_ready | output | 1 | Lookup accepted this cycle when high with miss_valid |
| lkp_hit | output | 1 | Accepted lookup found the block at the oldest entry |
| lkp_data | output | DATA_W | Block data of the oldest entry |
| mem_req_valid | output | 1 | Fetch request to the next level |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_addr | output | ADDR_W | Requested block address |
| mem_req_gen | output | GEN_W | Generation tag sent with the request |
| mem_rsp_valid | input | 1 | Response from the next level, in request order |
| mem_rsp_gen | input | GEN_W | Generation tag echoed from the request |
| mem_rsp_data | input | DATA_W | Response block data |

## Verification
The embedded properties assume three things about the next level. It returns exactly one response per accepted request. Responses come in issue order and echo the request's generation tag. A stream is never abandoned so many times that the generation wraps while one of its responses is still pending. The bench's memory model keeps these promises by construction: it queues accepted requests and answers them first in, first out after a set latency, with the captured tag. Runs that hold responses back, stretch the latency or toggle acceptance only delay answers and never reorder or invent them. Flush bursts stay far below the generation range.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   typedef enum logic [1:0] {
      SLOT_IDLE  = 2'd0,
      SLOT_NEED  = 2'd1,
      SLOT_PEND  = 2'd2,
      SLOT_READY = 2'd3
   } slot_st_e;
endpackage

// File: rtl/sbuf_slot.sv
module sbuf_slot
   import sbuf_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 64,
   parameter int SLOT_IDX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_base,
   input  logic              pop_here,
   input  logic [ADDR_W-1:0] pop_tag,
   input  logic              issue_here,
   input  logic              fill_here,
   input  logic [DATA_W-1:0] fill_data,
   output slot_st_e          st_o,
   output logic [ADDR_W-1:0] tag_o,
   output logic [DATA_W-1:0] data_o
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(SLOT_IDX);

   slot_st_e          st_q;
   logic [ADDR_W-1:0] tag_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SLOT_IDLE;
         tag_q  <= '0;
         data_q <= '0;
      end else if (flush) begin
         st_q  <= SLOT_NEED;
         tag_q <= flush_base + OFS;
      end else if (pop_here) begin
         st_q  <= SLOT_NEED;
         tag_q <= pop_tag;
      end else if (issue_here) begin
         st_q <= SLOT_PEND;
      end else if (fill_here) begin
         st_q   <= SLOT_READY;
         data_q <= fill_data;
      end
   end

   assign st_o   = st_q;
   assign tag_o  = tag_q;
   assign data_o = data_q;

   // R3: only a slot holding data may be handed to the cache
   a_r3_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      pop_here |-> st_q == SLOT_READY);

   // R10: a fill always lands on a slot waiting for a response
   a_r10_fill_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
      fill_here |-> st_q == SLOT_PEND);

   // R5: a requested slot never asks again unless the stream restarts
   a_r5_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SLOT_PEND && !flush) |=> (st_q == SLOT_PEND || st_q == SLOT_READY));
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
   import sbuf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4,
   parameter int GEN_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          miss_valid,
   input  logic [ADDR_W-1:0]             miss_addr,
   output logic                          miss_ready,
   output logic                          lkp_hit,
   output logic [DATA_W-1:0]             lkp_data,
   output logic                          mem_req_valid,
   input  logic                          mem_req_ready,
   output logic [ADDR_W-1:0]             mem_req_addr,
   output logic [GEN_W-1:0]              mem_req_gen,
   input  logic                          mem_rsp_valid,
   input  logic [GEN_W-1:0]              mem_rsp_gen,
   input  slot_st_e [DEPTH-1:0]          st_vec,
   input  logic [DEPTH-1:0][ADDR_W-1:0]  tag_vec,
   input  logic [DEPTH-1:0][DATA_W-1:0]  data_vec,
   output logic                          flush,
   output logic [ADDR_W-1:0]             flush_base,
   output logic [DEPTH-1:0]              pop_sel,
   output logic [ADDR_W-1:0]             pop_tag,
   output logic [DEPTH-1:0]              issue_sel,
   output logic [DEPTH-1:0]              fill_sel
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   function automatic logic [PW-1:0] ring_next(input logic [PW-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   function automatic logic [PW-1:0] ring_prev(input logic [PW-1:0] p);
      return (p == '0) ? LAST : p - 1'b1;
   endfunction

   logic [PW-1:0]     head_q, iptr_q, fptr_q;
   logic [ADDR_W-1:0] tail_q;
   logic [GEN_W-1:0]  gen_q;
   logic              active_q;

   logic head_match, head_ready, accept, pop, issue, fill;

   always_comb begin
      head_match    = active_q && (tag_vec[head_q] == miss_addr);
      head_ready    = (st_vec[head_q] == SLOT_READY);
      miss_ready    = !(head_match && !head_ready);
      accept        = miss_valid && miss_ready;
      pop           = accept && head_match;
      flush         = accept && !head_match;
      lkp_hit       = head_match && head_ready;
      lkp_data      = data_vec[head_q];
      mem_req_valid = (st_vec[iptr_q] == SLOT_NEED);
      mem_req_addr  = tag_vec[iptr_q];
      mem_req_gen   = gen_q;
      issue         = mem_req_valid && mem_req_ready;
      fill          = mem_rsp_valid && (mem_rsp_gen == gen_q) && !flush;
      flush_base    = miss_addr + 1'b1;
      pop_tag       = tail_q + 1'b1;
   end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_sel
      assign pop_sel[gi]   = pop   && (head_q == PW'(gi));
      assign issue_sel[gi] = issue && (iptr_q == PW'(gi));
      assign fill_sel[gi]  = fill  && (fptr_q == PW'(gi));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q   <= '0;
         iptr_q   <= '0;
         fptr_q   <= '0;
         tail_q   <= '0;
         gen_q    <= '0;
         active_q <= 1'b0;
      end else if (flush) begin
         head_q   <= '0;
         iptr_q   <= '0;
         fptr_q   <= '0;
         tail_q   <= miss_addr + ADDR_W'(DEPTH);
         gen_q    <= gen_q + 1'b1;
         active_q <= 1'b1;
      end else begin
         if (pop) begin
            head_q <= ring_next(head_q);
            tail_q <= tail_q + 1'b1;
         end
         if (issue) iptr_q <= ring_next(iptr_q);
         if (fill)  fptr_q <= ring_next(fptr_q);
      end
   end

   // R9: an unaccepted request holds its address and tag
   a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready && !flush) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_gen)));

   // R4: the newest slot always carries the last address requested so far
   a_r4_tail_chain: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> tail_q == tag_vec[ring_prev(head_q)]);

   // R2: every restart moves to a fresh generation
   a_r2_flush_gen: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> mem_req_gen == GEN_W'($past(mem_req_gen) + 1'b1));

   // R8: at most one slot changes through each path per cycle
   a_r8_single_sel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fill_sel) && $onehot0(issue_sel) && $onehot0(pop_sel));
endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
   import sbuf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4,
   parameter int GEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_addr,
   output logic              miss_ready,
   output logic              lkp_hit,
   output logic [DATA_W-1:0] lkp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [GEN_W-1:0]  mem_req_gen,
   input  logic              mem_rsp_valid,
   input  logic [GEN_W-1:0]  mem_rsp_gen,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("stream_prefetch_buf: DEPTH must be at least 2");
   end
   if (GEN_W < 1) begin : g_bad_gen
      $error("stream_prefetch_buf: GEN_W must be at least 1");
   end
   if (ADDR_W < 2 || DATA_W < 1) begin : g_bad_width
      $error("stream_prefetch_buf: address or data width too small");
   end

   slot_st_e [DEPTH-1:0]          st_vec;
   logic [DEPTH-1:0][ADDR_W-1:0]  tag_vec;
   logic [DEPTH-1:0][DATA_W-1:0]  data_vec;
   logic                          flush;
   logic [ADDR_W-1:0]             flush_base;
   logic [DEPTH-1:0]              pop_sel, issue_sel, fill_sel;
   logic [ADDR_W-1:0]             pop_tag;

   sbuf_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .GEN_W(GEN_W)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
      .lkp_hit(lkp_hit), .lkp_data(lkp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_gen(mem_req_gen),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_gen(mem_rsp_gen),
      .st_vec(st_vec), .tag_vec(tag_vec), .data_vec(data_vec),
      .flush(flush), .flush_base(flush_base),
      .pop_sel(pop_sel), .pop_tag(pop_tag),
      .issue_sel(issue_sel), .fill_sel(fill_sel)
   );

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      sbuf_slot #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_IDX(gi)
      ) slot_i (
         .clk(clk), .rst_n(rst_n),
         .flush(flush), .flush_base(flush_base),
         .pop_here(pop_sel[gi]), .pop_tag(pop_tag),
         .issue_here(issue_sel[gi]),
         .fill_here(fill_sel[gi]), .fill_data(mem_rsp_data),
         .st_o(st_vec[gi]), .tag_o(tag_vec[gi]), .data_o(data_vec[gi])
      );
   end
endmodule

// File: tb/stream_prefetch_buf_tb.sv
module stream_prefetch_buf_tb_top;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int K  = 4;
   localparam int GW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [AW-1:0] miss_addr = '0;
   logic          miss_ready, lkp_hit;
   logic [DW-1:0] lkp_data;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b0;
   logic [AW-1:0] mem_req_addr;
   logic [GW-1:0] mem_req_gen;
   logic          mem_rsp_valid = 1'b0;
   logic [GW-1:0] mem_rsp_gen = '0;
   logic [DW-1:0] mem_rsp_data = '0;

   always #5 clk = ~clk;

   stream_prefetch_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(K), .GEN_W(GW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
      .lkp_hit(lkp_hit), .lkp_data(lkp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_gen(mem_req_gen),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_gen(mem_rsp_gen),
      .mem_rsp_data(mem_rsp_data)
   );

   int n_tot = 0;
   int n_fail = 0;
   int cyc = 0;
   int ready_mode = 0;
   int lat = 3;
   bit hold_rsp = 1'b0;

   logic [AW-1:0] q_addr [64];
   logic [GW-1:0] q_gen [64];
   int            q_t [64];
   int            qh = 0, qt = 0;
   logic [AW-1:0] req_log [256];
   int            n_req = 0;

   function automatic logic [DW-1:0] mdat(input logic [AW-1:0] a);
      return {a, a ^ 8'hA5};
   endfunction

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_tot++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // next-level memory model: in-order, fixed latency, tag echoed
   initial begin
      forever begin
         @(negedge clk);
         case (ready_mode)
            0: mem_req_ready = 1'b1;
            1: mem_req_ready = cyc[0];
            default: mem_req_ready = 1'b0;
         endcase
         #1;
         if (mem_req_valid && mem_req_ready) begin
            q_addr[qt] = mem_req_addr;
            q_gen[qt]  = mem_req_gen;
            q_t[qt]    = cyc;
            qt = (qt + 1) % 64;
            req_log[n_req % 256] = mem_req_addr;
            n_req++;
         end
         mem_rsp_valid = 1'b0;
         if (!hold_rsp && qh != qt && (cyc - q_t[qh]) >= lat) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_gen   = q_gen[qh];
            mem_rsp_data  = mdat(q_addr[qh]);
            qh = (qh + 1) % 64;
         end
      end
   end

   task automatic do_lkp(input logic [AW-1:0] a, output logic h, output logic [DW-1:0] d,
                         output int stall);
      @(negedge clk);
      miss_valid = 1'b1;
      miss_addr  = a;
      stall = 0;
      #2;
      while (!miss_ready) begin
         @(negedge clk);
         #2;
         stall++;
      end
      h = lkp_hit;
      d = lkp_data;
      @(posedge clk);
      #1 miss_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tot++;
      n_fail++;
      $display("FAIL watchdog: run hung actual=%0d expected<20000", cyc);
      finish_run();
   end

   initial begin
      logic          h;
      logic [DW-1:0] d;
      int            st;
      int            base;
      int            bad;
      logic [AW-1:0] a0;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R1: empty after reset
      check("R1 miss_ready", 32'(miss_ready), 1);
      check("R1 lkp_hit", 32'(lkp_hit), 0);
      idle(4);
      check("R1 no request", 32'(n_req), 0);

      // R2: first lookup misses and starts the stream
      do_lkp(8'd10, h, d, st);
      check("R2 first lookup miss", 32'(h), 0);
      idle(12);
      check("R8 request count after start", 32'(n_req), K);
      bad = 0;
      for (int i = 0; i < K; i++) if (req_log[i] !== 8'(11 + i)) bad++;
      check("R2 start addresses in order", 32'(bad), 0);

      // R3/R4: head hit, then refill with newest+1
      do_lkp(8'd11, h, d, st);
      check("R3 head hit", 32'(h), 1);
      check("R3 head data", 32'(d), 32'(mdat(8'd11)));
      check("R3 no stall when ready", 32'(st), 0);
      idle(4);
      check("R4 refill address", 32'(req_log[K]), 32'(8'd15));

      // R3/R10 sweep of sequential hits
      for (int a = 12; a <= 30; a++) begin
         do_lkp(8'(a), h, d, st);
         check("R3 sweep hit", 32'(h), 1);
         check("R10 sweep data", 32'(d), 32'(mdat(8'(a))));
      end
      idle(10);
      check("R4 total requests after sweep", 32'(n_req), 24);
      bad = 0;
      for (int i = 0; i < 24; i++) if (req_log[i] !== 8'(11 + i)) bad++;
      check("R4 request chain", 32'(bad), 0);

      // R8/R5: pending head stalls, no duplicate request
      hold_rsp = 1'b1;
      base = n_req;
      do_lkp(8'd100, h, d, st);
      check("R2 new stream miss", 32'(h), 0);
      idle(10);
      check("R8 exactly K outstanding", 32'(n_req - base), K);
      fork
         begin idle(6); hold_rsp = 1'b0; end
         begin do_lkp(8'd101, h, d, st); end
      join
      check("R5 stalled on pending head", 32'(st >= 5), 1);
      check("R5 hit after fill", 32'(h), 1);
      check("R5 data after fill", 32'(d), 32'(mdat(8'd101)));
      idle(10);
      check("R5 no duplicate request", 32'(n_req - base), K + 1);
      check("R5 refill after stall", 32'(req_log[(base + K) % 256]), 32'(8'd105));

      // R6: address present but not at head is a miss
      base = n_req;
      do_lkp(8'd104, h, d, st);
      check("R6 non-head is miss", 32'(h), 0);
      idle(12);
      check("R6 restart count", 32'(n_req - base), K);
      check("R6 restart first addr", 32'(req_log[base % 256]), 32'(8'd105));
      do_lkp(8'd105, h, d, st);
      check("R6 hit on new head", 32'(h), 1);
      check("R6 new head data", 32'(d), 32'(mdat(8'd105)));

      // R7: stale responses from an abandoned stream are dropped
      lat = 8;
      do_lkp(8'd200, h, d, st);
      do_lkp(8'd50, h, d, st);
      check("R7 second restart miss", 32'(h), 0);
      idle(30);
      for (int a = 51; a <= 53; a++) begin
         do_lkp(8'(a), h, d, st);
         check("R7 hit after stale drop", 32'(h), 1);
         check("R7 data not stale", 32'(d), 32'(mdat(8'(a))));
      end
      lat = 3;
      idle(10);

      // R9: request held while not accepted
      ready_mode = 2;
      do_lkp(8'd70, h, d, st);
      @(negedge clk);
      #2;
      a0 = mem_req_addr;
      check("R9 first held address", 32'(a0), 32'(8'd71));
      bad = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         #2;
         if (!mem_req_valid || mem_req_addr !== a0) bad++;
      end
      check("R9 request stable", 32'(bad), 0);

      // R10 under alternating acceptance
      ready_mode = 1;
      idle(16);
      bad = 0;
      for (int a = 71; a <= 90; a++) begin
         do_lkp(8'(a), h, d, st);
         if (h !== 1'b1 || d !== mdat(8'(a))) bad++;
      end
      check("R10 hits with throttled memory", 32'(bad), 0);

      idle(5);
      finish_run();
   end
endmodule